// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects event pulses from eighteen interrupt sources and turns them into a single request for a small CPU core. Three of the sources are external pins, and each pin can be set to react to either its rising or its falling edge. The other fifteen arrive as single-cycle event pulses from on-chip peripherals: port change, four timers, ADC complete, two capture/compare units, serial receive and transmit, a parallel slave port, a synchronous serial port, low-voltage detect, bus collision and nonvolatile write.

Every source has a sticky flag and an enable. Every source except external pin 0 also has a priority bit. Pin 0 is always high priority. With the priority scheme switched on, high and low requests have their own global enables and their own vector addresses. Entering a handler clears the enable of its level. A return restores that enable, using a two-entry level stack. Because only the low enable is cleared on a low entry, a high request can preempt a running low handler.

Software sees four registers through a simple register port: flags, enables, priorities and control. The CPU side is a request/vector output pair with acknowledge and return inputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Register 0 holds the flags, with bit i belonging to source i. External pin j is source j (j = 0..2), and evtIn[k] is source k+3. A flag is set by its event whether or not the source is enabled, and it stays set while register 0 is not written.
- R2: Writing register 0 clears each flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. If an event for a source arrives in the same cycle as a clear of its flag, the flag ends up set.
- R3: Control register 3 bits 3..5 select the active edge of pins 0..2 (0 = falling, 1 = rising). A pin change made before a rising clock edge sets the flag after the third such edge and not after the second. A change in the other direction sets no flag.
- R4: Register 1 holds the enables. Register 2 holds the priority bits (1 = high). Bit 0 of register 2 always reads 1, and writes to it are ignored.
- R5: With control bit 0 (priority-enable) at 1, an enabled pending high source together with control bit 1 (high enable) raises irqReq with vector 0x0008. An enabled pending low source needs both bit 1 and bit 2 (low enable), and it raises vector 0x0018. High wins when both levels qualify.
- R6: With priority-enable at 0, any enabled pending source together with the high enable raises irqReq with vector 0x0008. Priority bits and the low enable are ignored.
- R7: After reset the flags, enables and control read 0, the priority register reads 1, and irqReq is 0.
- R8: irqAck while a high request is presented clears only the high enable. irqAck while a low request is presented clears only the low enable. irqAck with no request changes nothing.
- R9: irqRet sets the enable cleared by the most recent entry that has not yet returned, tracked over two nesting levels. irqRet with nothing recorded sets the high enable.
- R10: While a low handler runs (low enable cleared), an enabled pending high source still raises irqReq with vector 0x0008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register select: 0 flags, 1 enables, 2 priorities, 3 control |
| regWr | input | 1 | Write strobe for the selected register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the selected register (combinational) |
| evtIn | input | 15 | Internal event pulses; bit k is source k+3 |
| extPin | input | 3 | Asynchronous external interrupt pins |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqVec | output | 16 | Vector address for the presented request |
| irqAck | input | 1 | CPU accepts the presented request |
| irqRet | input | 1 | CPU returns from a handler |

## Verification
The bench targets the clear-versus-event race on a flag. A design that lets the clear win there would silently lose an interrupt. Pin edges are timed to the exact cycle. Latency that is off by one, or an inverted edge select, shows up as a flag that appears too early, too late, or on the wrong edge. A nested low-then-high entry with two returns checks that each return restores the right enable. A stack that is lost or inverted would leave low interrupts masked, or would unmask high ones inside a handler. Random register traffic with sparse events checks the request and vector against a reference model. This exposes mixed-up gating of the two global enables, and priority-enable being ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic [1:0] ADDR_FLAG = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_PRIO = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  localparam logic [15:0] VEC_HI = 16'h0008;
  localparam logic [15:0] VEC_LO = 16'h0018;

  typedef struct packed {
    logic clrHi;
    logic clrLo;
    logic setHi;
    logic setLo;
  } gieStrobe_t;
endpackage

// File: rtl/irqc_data.sv
module irqc_data
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 18,
  parameter int NUM_EXT = 3,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 regAddr,
  input  logic                       regWr,
  input  logic [DATA_W-1:0]          regWdata,
  output logic [DATA_W-1:0]          regRdata,
  input  logic [NUM_SRC-NUM_EXT-1:0] evtIn,
  input  logic [NUM_EXT-1:0]         extPin,
  input  gieStrobe_t                 strobe,
  output logic [NUM_SRC-1:0]         pendVec,
  output logic [NUM_SRC-1:0]         prioVec,
  output logic                       prioEn,
  output logic                       gieHi,
  output logic                       gieLo
);
  localparam int CTRL_W = 3 + NUM_EXT;

  logic [NUM_SRC-1:0] flagQ, enQ, srcHit, flagKeep;
  logic [NUM_SRC-1:1] prioQ;
  logic [NUM_EXT-1:0] edgeSelQ, edgeHit;
  logic prioEnQ, gieHiQ, gieLoQ;
  logic wrFlag, wrEn, wrPrio, wrCtrl;
  logic unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:NUM_SRC];

  assign wrFlag = regWr && (regAddr == ADDR_FLAG);
  assign wrEn   = regWr && (regAddr == ADDR_EN);
  assign wrPrio = regWr && (regAddr == ADDR_PRIO);
  assign wrCtrl = regWr && (regAddr == ADDR_CTRL);

  // External pin synchronizers and edge detectors
  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    logic s1, s2, prev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= extPin[i];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign edgeHit[i] = edgeSelQ[i] ? (s2 & ~prev) : (~s2 & prev);

    // R3
    ext_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      edgeHit[i] |=> flagQ[i]);
  end

  assign srcHit   = {evtIn, edgeHit};
  assign flagKeep = wrFlag ? (flagQ & regWdata[NUM_SRC-1:0]) : flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      prioQ <= '0;
    end else begin
      flagQ <= flagKeep | srcHit;
      if (wrEn)   enQ   <= regWdata[NUM_SRC-1:0];
      if (wrPrio) prioQ <= regWdata[NUM_SRC-1:1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioEnQ  <= 1'b0;
      gieHiQ   <= 1'b0;
      gieLoQ   <= 1'b0;
      edgeSelQ <= '0;
    end else begin
      if (wrCtrl) begin
        prioEnQ  <= regWdata[0];
        gieHiQ   <= regWdata[1];
        gieLoQ   <= regWdata[2];
        edgeSelQ <= regWdata[3 +: NUM_EXT];
      end
      if (strobe.clrHi) gieHiQ <= 1'b0;
      if (strobe.setHi) gieHiQ <= 1'b1;
      if (strobe.clrLo) gieLoQ <= 1'b0;
      if (strobe.setLo) gieLoQ <= 1'b1;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_FLAG: regRdata[NUM_SRC-1:0] = flagQ;
      ADDR_EN:   regRdata[NUM_SRC-1:0] = enQ;
      ADDR_PRIO: regRdata[NUM_SRC-1:0] = {prioQ, 1'b1};
      default:   regRdata[CTRL_W-1:0]  = {edgeSelQ, gieLoQ, gieHiQ, prioEnQ};
    endcase
  end

  assign pendVec = flagQ & enQ;
  assign prioVec = {prioQ, 1'b1};
  assign prioEn  = prioEnQ;
  assign gieHi   = gieHiQ;
  assign gieLo   = gieLoQ;

  // R1
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrFlag |=> ((flagQ & $past(flagQ)) == $past(flagQ)));
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 18,
  parameter int STACK_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendVec,
  input  logic [NUM_SRC-1:0] prioVec,
  input  logic               prioEn,
  input  logic               gieHi,
  input  logic               gieLo,
  input  logic               irqAck,
  input  logic               irqRet,
  output logic               irqReq,
  output logic [15:0]        irqVec,
  output gieStrobe_t         strobe
);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic hiAny, loAny, hiReq, loReq, takeAck, topHigh, doPush, doPop;
  logic [STACK_DEPTH-1:0] lvlStack;
  logic [CNT_W-1:0] depth, depthM1;

  assign hiAny = prioEn ? |(pendVec & prioVec) : |pendVec;
  assign loAny = prioEn & |(pendVec & ~prioVec);
  assign hiReq = hiAny & gieHi;
  assign loReq = loAny & gieHi & gieLo;

  assign irqReq = hiReq | loReq;
  assign irqVec = hiReq ? VEC_HI : VEC_LO;

  assign takeAck = irqAck & irqReq & ~irqRet;
  assign depthM1 = depth - CNT_W'(1);
  assign topHigh = (depth == '0) ? 1'b1 : lvlStack[depthM1[IDX_W-1:0]];
  assign doPush  = takeAck && (depth != CNT_W'(STACK_DEPTH));
  assign doPop   = irqRet && (depth != '0);

  always_comb begin
    strobe       = '0;
    strobe.clrHi = takeAck & hiReq;
    strobe.clrLo = takeAck & ~hiReq;
    strobe.setHi = irqRet & topHigh;
    strobe.setLo = irqRet & ~topHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth    <= '0;
      lvlStack <= '0;
    end else if (doPush) begin
      lvlStack[depth[IDX_W-1:0]] <= hiReq;
      depth <= depth + CNT_W'(1);
    end else if (doPop) begin
      depth <= depthM1;
    end
  end

  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    depth <= CNT_W'(STACK_DEPTH));

  // R5
  lo_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqVec == VEC_LO) |-> (gieLo && gieHi && prioEn));

  // R10
  hi_preempt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prioEn && gieHi && !gieLo && |(pendVec & prioVec)) |-> (irqReq && irqVec == VEC_HI));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 18,
  parameter int NUM_EXT     = 3,
  parameter int DATA_W      = 32,
  parameter int STACK_DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 regAddr,
  input  logic                       regWr,
  input  logic [DATA_W-1:0]          regWdata,
  output logic [DATA_W-1:0]          regRdata,
  input  logic [NUM_SRC-NUM_EXT-1:0] evtIn,
  input  logic [NUM_EXT-1:0]         extPin,
  output logic                       irqReq,
  output logic [15:0]                irqVec,
  input  logic                       irqAck,
  input  logic                       irqRet
);
  gieStrobe_t strobe;
  logic [NUM_SRC-1:0] pendVec, prioVec;
  logic prioEn, gieHi, gieLo;

  irqc_data #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .evtIn(evtIn), .extPin(extPin), .strobe(strobe),
    .pendVec(pendVec), .prioVec(prioVec), .prioEn(prioEn), .gieHi(gieHi), .gieLo(gieLo)
  );

  irqc_ctrl #(.NUM_SRC(NUM_SRC), .STACK_DEPTH(STACK_DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .prioVec(prioVec), .prioEn(prioEn),
    .gieHi(gieHi), .gieLo(gieLo), .irqAck(irqAck), .irqRet(irqRet),
    .irqReq(irqReq), .irqVec(irqVec), .strobe(strobe)
  );

  // R8
  hi_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !irqRet && irqReq && irqVec == VEC_HI && !(regWr && regAddr == ADDR_CTRL))
      |=> (!gieHi && gieLo == $past(gieLo)));

  // R8
  lo_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !irqRet && irqReq && irqVec == VEC_LO && !(regWr && regAddr == ADDR_CTRL))
      |=> (!gieLo && gieHi == $past(gieHi)));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [14:0] evtIn = '0;
  logic [2:0] extPin = '0;
  logic irqReq;
  logic [15:0] irqVec;
  logic irqAck = 1'b0;
  logic irqRet = 1'b0;

  int errors = 0;
  int checks = 0;

  logic [17:0] mFlag, mEn, mPrio;
  logic [5:0] mCtrl;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .evtIn(evtIn), .extPin(extPin), .irqReq(irqReq),
    .irqVec(irqVec), .irqAck(irqAck), .irqRet(irqRet)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] d,
                      input logic [14:0] ev, input logic ack, input logic ret);
    @(negedge clk);
    regWr = wr; regAddr = a; regWdata = d; evtIn = ev; irqAck = ack; irqRet = ret;
    @(posedge clk);
    #1;
    regWr = 1'b0; evtIn = '0; irqAck = 1'b0; irqRet = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    step(1'b1, a, d, '0, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  function automatic logic expReq(input logic [17:0] f, input logic [17:0] e,
                                  input logic [17:0] p, input logic [5:0] c);
    logic [17:0] pend;
    pend = f & e;
    if (!c[0]) return c[1] && (pend != 0);
    return (c[1] && ((pend & p) != 0)) || (c[1] && c[2] && ((pend & ~p) != 0));
  endfunction

  function automatic logic [15:0] expVec(input logic [17:0] f, input logic [17:0] e,
                                         input logic [17:0] p, input logic [5:0] c);
    logic [17:0] pend;
    pend = f & e;
    if (!c[0] || ((pend & p) != 0)) return 16'h0008;
    return 16'h0018;
  endfunction

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R7 reset state
    rd(2'd0, v); chk("R7 flags", v, 32'h0);
    rd(2'd1, v); chk("R7 enables", v, 32'h0);
    rd(2'd2, v); chk("R7 prio", v, 32'h1);
    rd(2'd3, v); chk("R7 ctrl", v, 32'h0);
    chk("R7 req", irqReq, 1'b0);

    // R1 flag set while disabled (source 9 = evtIn[6])
    step(1'b0, 2'd0, 0, 15'h0040, 1'b0, 1'b0);
    rd(2'd0, v); chk("R1 flag set disabled", v, 32'h200);
    repeat (3) step(1'b0, 2'd0, 0, 15'h0, 1'b0, 1'b0);
    rd(2'd0, v); chk("R1 flag sticky", v, 32'h200);

    // R2 clear vs event race on source 5 (evtIn[2])
    step(1'b0, 2'd0, 0, 15'h0004, 1'b0, 1'b0);
    step(1'b1, 2'd0, 32'h0, 15'h0004, 1'b0, 1'b0);
    rd(2'd0, v); chk("R2 event beats clear", v, 32'h20);
    wr(2'd0, 32'h3FFDF);
    rd(2'd0, v); chk("R2 write 1 keeps, 0 clears", v, 32'h0);

    // R4 priority bit 0 hardwired
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R4 prio bit0 reads 1", v, 32'h1);
    wr(2'd1, 32'h12345);
    rd(2'd1, v); chk("R4 enable reg", v, 32'h12345);
    wr(2'd1, 32'h0);

    // R3 pin 1 rising edge
    wr(2'd3, 32'h10);
    @(negedge clk); extPin[1] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rd(2'd0, v); chk("R3 not after 2 edges", v, 32'h0);
    // rd consumed one negedge; third edge comes next
    @(posedge clk); #1;
    rd(2'd0, v); chk("R3 set after 3 edges", v, 32'h2);
    wr(2'd0, 32'h0);
    @(negedge clk); extPin[1] = 1'b0;
    repeat (5) @(posedge clk); #1;
    rd(2'd0, v); chk("R3 falling ignored in rising mode", v, 32'h0);
    // pin 0 in falling mode
    @(negedge clk); extPin[0] = 1'b1;
    repeat (5) @(posedge clk); #1;
    rd(2'd0, v); chk("R3 rising ignored in falling mode", v, 32'h0);
    @(negedge clk); extPin[0] = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    rd(2'd0, v); chk("R3 falling edge sets pin0 flag", v, 32'h1);
    wr(2'd0, 32'h0);

    // R5 levels: source 4 low (evtIn[1]), source 6 high (evtIn[3])
    wr(2'd2, 32'h40);
    wr(2'd1, 32'h50);
    wr(2'd3, 32'h3);
    step(1'b0, 2'd0, 0, 15'h0002, 1'b0, 1'b0);
    chk("R5 low blocked without low enable", irqReq, 1'b0);
    wr(2'd3, 32'h7);
    chk("R5 low req", irqReq, 1'b1);
    chk("R5 low vector", irqVec, 32'h18);

    // R6 priority scheme off
    wr(2'd3, 32'h2);
    chk("R6 single-level req", irqReq, 1'b1);
    chk("R6 single-level vector", irqVec, 32'h8);

    // R8 / R10 / R9 nesting
    wr(2'd3, 32'h7);
    step(1'b0, 2'd0, 0, 15'h0, 1'b1, 1'b0);
    rd(2'd3, v); chk("R8 low ack clears low enable only", v, 32'h3);
    chk("R8 low masked after entry", irqReq, 1'b0);
    step(1'b0, 2'd0, 0, 15'h0008, 1'b0, 1'b0);
    chk("R10 high preempts low", irqReq, 1'b1);
    chk("R10 high vector", irqVec, 32'h8);
    step(1'b0, 2'd0, 0, 15'h0, 1'b1, 1'b0);
    rd(2'd3, v); chk("R8 high ack clears high enable", v, 32'h1);
    chk("R8 no req in high handler", irqReq, 1'b0);
    step(1'b0, 2'd0, 0, 15'h0, 1'b0, 1'b0);
    step(1'b0, 2'd0, 0, 15'h0, 1'b1, 1'b0);
    rd(2'd3, v); chk("R8 ack without req ignored", v, 32'h1);
    wr(2'd0, 32'h3FFBF);
    step(1'b0, 2'd0, 0, 15'h0, 1'b0, 1'b1);
    rd(2'd3, v); chk("R9 first return restores high", v, 32'h3);
    step(1'b0, 2'd0, 0, 15'h0, 1'b0, 1'b1);
    rd(2'd3, v); chk("R9 second return restores low", v, 32'h7);
    wr(2'd3, 32'h5);
    step(1'b0, 2'd0, 0, 15'h0, 1'b0, 1'b1);
    rd(2'd3, v); chk("R9 empty return sets high", v, 32'h7);

    // Random traffic against the model (R1 R2 R5 R6)
    wr(2'd0, 32'h0); mFlag = '0;
    wr(2'd1, 32'h0); mEn = '0;
    wr(2'd2, 32'h0); mPrio = 18'h1;
    wr(2'd3, 32'h0); mCtrl = '0;
    for (int n = 0; n < 400; n++) begin
      logic dw;
      logic [1:0] a;
      logic [31:0] d;
      logic [14:0] ev;
      dw = ($urandom % 3) == 0;
      a = 2'($urandom);
      d = $urandom;
      if (a == 2'd3) d = d & 32'h7;
      ev = 15'($urandom & $urandom & $urandom);
      step(dw, a, d, ev, 1'b0, 1'b0);
      if (dw) begin
        case (a)
          2'd0: mFlag = mFlag & d[17:0];
          2'd1: mEn = d[17:0];
          2'd2: mPrio = {d[17:1], 1'b1};
          default: mCtrl = d[5:0];
        endcase
      end
      mFlag = mFlag | {ev, 3'b000};
      chk("R5 R6 random req", irqReq, expReq(mFlag, mEn, mPrio, mCtrl));
      if (expReq(mFlag, mEn, mPrio, mCtrl))
        chk("R5 R6 random vector", irqVec, expVec(mFlag, mEn, mPrio, mCtrl));
      rd(2'd0, v);
      chk("R1 R2 random flags", v, {14'h0, mFlag});
    end

    finishRun();
  end
endmodule